// File: doc/BRIEF.md
# Single-Wire Debug Sync Responder

This block sits on the target side of a bidirectional, open-drain style debug pin. It watches the pin for a host-driven low that lasts far longer than any data bit. Such a low is taken as a request to resynchronise. The block flushes the serial command receiver, which has the same effect as a serial time-out. If an acknowledge pulse was pending, the block cancels it. It then waits for the host to let the line go high.

Once the line is high, the block holds off for a short guard interval, so the host can finish its own speedup drive. It then pulls the pin low for a fixed number of serial bit-clock periods. After that it drives the pin high for one period to sharpen the rising edge, and then releases the pin. The host measures that low pulse to learn the target's bit rate. The serial bit clock comes in as a one-cycle enable, `bit_tick`, issued once every eight core clocks. After the reply, the next host low is again measured from zero.

The controller is a six-state machine:

- **IDLE**: measure host lows. The transition *detect* goes to WAIT_HIGH when a low reaches the threshold.
- **WAIT_HIGH**: wait for the line. The transition *line_up* goes to GAP on a tick that sees the synchronised line high.
- **GAP**: the guard interval. The transition *gap_done* goes to DRIVE_LOW.
- **DRIVE_LOW**: hold the reference low. The transition *low_done* goes to DRIVE_HIGH.
- **DRIVE_HIGH**: one-tick speedup. The transition *high_done* goes to RELEASE.
- **RELEASE**: a one-clock state. The transition *finish* returns to IDLE.

Top module: `sdr_sync_responder`

## Requirements
- R1: After reset, `line_oe`, `line_out`, `rx_flush`, `ack_abort` and `reply_done` are all 0.
- R2: A low on `line_in` that spans fewer than SYNC_MIN_TICKS (default 64) ticks produces no flush and no pin drive.
- R3: A low that spans SYNC_MIN_TICKS ticks produces exactly one `rx_flush` pulse, one clock wide.
- R4: After detection, the pin is never driven while the line is still held low, however long the low lasts.
- R5: The drive begins on the GAP_TICKS-th (default 16) tick after the first tick on which the synchronised line is high. The two-stage input synchroniser adds one further tick when the host releases on a tick.
- R6: The reference low is driven (`line_oe`=1, `line_out`=0) for exactly LOW_TICKS (default 128) tick periods.
- R7: The low is followed by exactly one tick period of active high drive (`line_oe`=1, `line_out`=1). The pin is then released, and `reply_done` pulses for one clock.
- R8: `ack_abort` pulses together with `rx_flush` when `ack_pend` is 1 at detection, and stays 0 otherwise. The reply is the same in both cases.
- R9: The low-width count restarts whenever the line is seen high, so two short lows separated by a high never count as a request.
- R10: After `reply_done`, a new long low is detected and answered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-clock enable at the serial bit rate |
| line_in | input | 1 | Sensed level of the debug pin |
| ack_pend | input | 1 | An acknowledge pulse is pending |
| line_oe | output | 1 | Pin drive enable |
| line_out | output | 1 | Pin drive level when enabled |
| rx_flush | output | 1 | Soft-reset pulse to the command receiver |
| ack_abort | output | 1 | Cancels the pending acknowledge |
| reply_done | output | 1 | One-clock pulse when the pin is released |

## Verification
The assertions assume that `bit_tick` is never high on two consecutive clocks, so each high drive lasts one whole tick period. They also assume that `ack_pend` is steady around detection. The bench generates the tick from a divide-by-eight counter and changes `ack_pend` only while the line is idle. It models the pin as a wired line in which the host's low overrides everything and released means high. The low lengths are kept several ticks clear of the threshold, so the synchroniser's skew of up to one tick cannot change the outcome.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HIGH,
        ST_GAP,
        ST_DRIVE_LOW,
        ST_DRIVE_HIGH,
        ST_RELEASE
    } sdr_state_e;
endpackage

// File: rtl/sdr_line_sync.sv
module sdr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/sdr_low_meter.sv
module sdr_low_meter #(
    parameter int THRESH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic line_s,
    output logic long_low
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIM = CW'(THRESH);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!en || line_s)      cnt <= '0;
        else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign long_low = (cnt == LIM);

    // R9: the count saturates at the limit and never wraps
    p_meter_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
    // R9: a high line always clears the count on the next clock
    p_meter_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> (cnt == '0));
endmodule

// File: rtl/sdr_tick_timer.sv
module sdr_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign expire = tick && (cnt == {{(W-1){1'b0}}, 1'b1});

    // R6: an interval is never loaded with zero
    p_load_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/sdr_sync_responder.sv
module sdr_sync_responder
    import sdr_pkg::*;
#(
    parameter int SYNC_MIN_TICKS = 64,
    parameter int GAP_TICKS      = 16,
    parameter int LOW_TICKS      = 128,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic line_in,
    input  logic ack_pend,
    output logic line_oe,
    output logic line_out,
    output logic rx_flush,
    output logic ack_abort,
    output logic reply_done
);
    localparam int TMAX  = (GAP_TICKS > LOW_TICKS) ? GAP_TICKS : LOW_TICKS;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam logic [TMR_W-1:0] GAP_V = TMR_W'(GAP_TICKS);
    localparam logic [TMR_W-1:0] LOW_V = TMR_W'(LOW_TICKS);

    sdr_state_e       state, state_nx;
    logic             line_s;
    logic             long_low;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expire;

    sdr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_s)
    );

    sdr_low_meter #(.THRESH(SYNC_MIN_TICKS)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state == ST_IDLE),
        .tick    (bit_tick),
        .line_s  (line_s),
        .long_low(long_low)
    );

    sdr_tick_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions and interval loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = GAP_V;
        unique case (state)
            ST_IDLE: begin
                if (long_low) state_nx = ST_WAIT_HIGH;          // detect
            end
            ST_WAIT_HIGH: begin
                if (bit_tick && line_s) begin                   // line_up
                    state_nx = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_V;
                end
            end
            ST_GAP: begin
                if (tmr_expire) begin                           // gap_done
                    state_nx = ST_DRIVE_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LOW_V;
                end
            end
            ST_DRIVE_LOW: begin
                if (tmr_expire) state_nx = ST_DRIVE_HIGH;       // low_done
            end
            ST_DRIVE_HIGH: begin
                if (bit_tick) state_nx = ST_RELEASE;            // high_done
            end
            ST_RELEASE: begin
                state_nx = ST_IDLE;                             // finish
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        line_oe    = (state == ST_DRIVE_LOW) || (state == ST_DRIVE_HIGH);
        line_out   = (state == ST_DRIVE_HIGH);
        reply_done = (state == ST_RELEASE);
        rx_flush   = (state == ST_IDLE) && long_low;
        ack_abort  = rx_flush && ack_pend;
    end

    // R3: the flush is a single-clock pulse
    p_flush_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_flush);
    // R8: a cancel only comes with a flush and a pending acknowledge
    p_abort_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_abort |-> (ack_pend && rx_flush));
    // R4/R5: the drive opens low, and only while the line reads high
    p_drive_opens_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> (!line_out && $past(line_s)));
    // R7: the pin is released only from the high speedup drive
    p_release_from_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> $past(line_out));
    // R7: the high drive ends at the tick that closes it
    p_high_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out && bit_tick) |=> !line_oe);
    // R7: done follows the high drive immediately
    p_done_after_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reply_done |-> (!line_oe && $past(line_oe && line_out)));
    // R1: drive level is never high without the enable
    p_out_needs_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_out |-> line_oe);
endmodule

// File: tb/sim_sdr_sync_responder.sv
`timescale 1ns/1ps
module sim_sdr_sync_responder;
    localparam int TDIV     = 8;
    localparam int MIN_T    = 64;
    localparam int GAP_T    = 16;
    localparam int LOW_T    = 128;
    localparam int EXP_LOW  = LOW_T * TDIV;
    localparam int EXP_HIGH = TDIV;
    localparam int EXP_GAP  = GAP_T + 2;  // tick consumed while sync still low + line_up tick

    typedef struct packed {
        logic [15:0] low;
        logic        ack;
        logic        sync;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd20,  1'b0, 1'b0},
        '{16'd61,  1'b1, 1'b0},
        '{16'd67,  1'b0, 1'b1},
        '{16'd100, 1'b1, 1'b1},
        '{16'd5,   1'b1, 1'b0},
        '{16'd150, 1'b0, 1'b1},
        '{16'd70,  1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic ack_pend = 1'b0;
    logic host_low = 1'b0;
    logic line_in;
    logic line_oe, line_out, rx_flush, ack_abort, reply_done;

    int tests = 0, fails = 0, div = 0;
    int low_clk, hi_clk, flush_n, abort_n, done_n, gap_n, drv_low_n;
    logic tick_prev, gap_on;
    bit   finished = 0;

    always #10 clk = ~clk;

    assign line_in = host_low ? 1'b0 : (line_oe ? line_out : 1'b1);

    sdr_sync_responder #(
        .SYNC_MIN_TICKS(MIN_T), .GAP_TICKS(GAP_T), .LOW_TICKS(LOW_T)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_in(line_in),
        .ack_pend(ack_pend), .line_oe(line_oe), .line_out(line_out),
        .rx_flush(rx_flush), .ack_abort(ack_abort), .reply_done(reply_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        low_clk = 0; hi_clk = 0; flush_n = 0; abort_n = 0;
        done_n = 0; gap_n = 0; drv_low_n = 0; gap_on = 1'b0;
    endtask

    // one clock: sample at the falling edge, then set the next tick
    task automatic step();
        @(negedge clk);
        tick_prev = bit_tick;
        if (line_oe && !line_out) low_clk++;
        if (line_oe && line_out)  hi_clk++;
        if (rx_flush)   flush_n++;
        if (ack_abort)  abort_n++;
        if (reply_done) done_n++;
        if (host_low && line_oe) drv_low_n++;
        if (gap_on && tick_prev) gap_n++;
        if (gap_on && line_oe) gap_on = 1'b0;
        div = (div == TDIV - 1) ? 0 : div + 1;
        bit_tick = (div == 0);
    endtask

    // hold the line low for n ticks, then release on a tick
    task automatic host_pulse(input int n);
        int k;
        k = 0;
        host_low = 1'b1;
        while (k < n) begin
            step();
            if (tick_prev) k++;
        end
        do step(); while (!bit_tick);
        host_low = 1'b0;
        gap_on = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_n == 0; i++) step();
        repeat (20) step();
    endtask

    task automatic check_reply(input string tag, input int ack);
        chk({tag, " R3 flush count"}, flush_n, 1);
        chk({tag, " R8 abort count"}, abort_n, ack);
        chk({tag, " R4 drive while host low"}, drv_low_n, 0);
        chk({tag, " R5 ticks to drive"}, gap_n, EXP_GAP);
        chk({tag, " R6 low clocks"}, low_clk, EXP_LOW);
        chk({tag, " R7 high clocks"}, hi_clk, EXP_HIGH);
        chk({tag, " R7 done pulses"}, done_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clear_counts();
        repeat (5) step();
        // R1: reset state
        chk("R1 oe",    int'(line_oe), 0);
        chk("R1 out",   int'(line_out), 0);
        chk("R1 flush", int'(rx_flush), 0);
        chk("R1 abort", int'(ack_abort), 0);
        chk("R1 done",  int'(reply_done), 0);
        rst_n = 1'b1;
        repeat (20) step();

        // vector table
        for (int v = 0; v < NV; v++) begin
            clear_counts();
            ack_pend = VECS[v].ack;
            host_pulse(int'(VECS[v].low));
            if (VECS[v].sync) begin
                wait_done();
                check_reply($sformatf("vec%0d R10", v), int'(VECS[v].ack));
            end else begin
                repeat (40) step();
                chk($sformatf("vec%0d R2 flush", v), flush_n, 0);
                chk($sformatf("vec%0d R2 drive", v), low_clk + hi_clk, 0);
            end
            ack_pend = 1'b0;
            repeat (10) step();
        end

        // R4: very long hold after detection
        clear_counts();
        host_pulse(400);
        wait_done();
        check_reply("long R4", 0);

        // R9: two short lows split by a brief high
        clear_counts();
        host_pulse(40);
        repeat (3 * TDIV) step();
        host_pulse(40);
        repeat (40) step();
        chk("R9 split flush", flush_n, 0);
        chk("R9 split drive", low_clk + hi_clk, 0);

        // R10: new request right after done
        clear_counts();
        host_pulse(80);
        wait_done();
        chk("R10 back-to-back first done", done_n, 1);
        clear_counts();
        host_pulse(80);
        wait_done();
        check_reply("R10 back-to-back second", 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule